// File: doc/BRIEF.md
# Calendar Real-Time Clock with Register Access

This block keeps wall-clock time and date: seconds, minutes, hours, day of month, month, a year within the century and the century itself. Software sees two packed binary time words, a control register and two alarm-side registers that read as zero, all on a small 32-bit word-addressed register bus. The bus has separate read and write strobes and combinational read data. A single-cycle tick input, produced elsewhere at one pulse per second, moves the time forward by one second whenever counting is enabled.

Setting the time is protected. A write to a time word only takes effect after software sets the unlock bit in the control register. The enable bit starts and stops the running clock. While counting is enabled, a read of a time word returns the live time and keeps a copy of it in that word's holding register. While counting is stopped, a read returns whatever that holding register last received, either from an unlocked write or from an enabled read. Rollover follows the calendar, with 28, 29, 30 or 31 day months and the Gregorian leap-year rule applied to the full four-digit year.

Top module: `cal_rtc`

## Requirements
- R1: After reset every register reads zero, counting is stopped and both control bits are clear.
- R2: Register word index is address bits [ADDR_W-1:2] and address bits [1:0] are ignored. Index 0 is time word A, 1 is time word B, 2 is the alarm value, 4 is control and 5 is alarm status. Time word A holds day of month in [28:24], hour in [20:16], minute in [13:8] and second in [5:0], all plain binary. Its other bits read zero.
- R3: Time word B holds century in [20:16], year within century (0..99) in [14:8] and month (1..12) in [3:0]. Its other bits read zero.
- R4: A write to either time word while control bit 1 (unlock) is clear changes neither the time nor what that word reads. While unlock is set, the written fields replace the current time and the word's holding register on the next clock edge.
- R5: A write to control always takes effect. Bit 0 is enable and bit 1 is unlock. Control reads back those two bits with all other bits zero.
- R6: On every clock edge where tick is high and enable is set, the time advances by exactly one second. When enable is clear, tick has no effect. In a cycle that loads a time word, the load wins over the tick.
- R7: Seconds and minutes wrap from 59 to 0 and hours from 23 to 0, each wrap carrying into the next field.
- R8: The day wraps to 1 after the last day of the month: 30 days in months 4, 6, 9 and 11, 31 in the other months except February. A day wrap increments the month.
- R9: February has 29 days when the full year (century*100 + year) is divisible by 4 but not by 100, or is divisible by 400. Otherwise it has 28.
- R10: Month wraps from 12 to 1 and increments the year. Year wraps from 99 to 0 and increments the century.
- R11: While enable is set, a time-word read returns the live time and stores it in that word's holding register. While enable is clear, the read returns the holding register.
- R12: Reads of the alarm, alarm status and any unmapped index return zero. Writes to them have no effect. Read data is zero whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second advance pulse |
| busAddr | input | ADDR_W | Byte address, word aligned |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational, valid while busRd is high |

## Verification
A wrong counter or carry shows up at the next time-word read after the faulty tick. The fault then stays visible, because later ticks build on the corrupted value. Faults in month length or the leap rule only appear on the last day of a month, so the bench loads the end of every month across years chosen to cover each branch of the leap rule, then reads one tick later. A broken holding register or lock can only be seen by reading with enable cleared, or by reading after a locked write. The bench reads in both of those states.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

  // word indices (address >> 2)
  localparam int IDX_TIME_A = 0;
  localparam int IDX_TIME_B = 1;
  localparam int IDX_ALARM  = 2;
  localparam int IDX_CTRL   = 4;
  localparam int IDX_ASTAT  = 5;

  // control bits
  localparam int CTL_EN     = 0;
  localparam int CTL_UNLOCK = 1;

  // implemented bits of each time word
  localparam logic [31:0] TIME_A_MASK = 32'h1F1F_3F3F;
  localparam logic [31:0] TIME_B_MASK = 32'h001F_7F0F;

  typedef struct packed {
    logic [1:0] load;     // unlocked write into time word [i]
    logic [1:0] snap;     // enabled read of time word [i]
    logic       advance;  // one-second step
  } rtcStrobe_t;

  function automatic logic [31:0] packTimeA(input logic [4:0] day, input logic [4:0] hour,
                                            input logic [5:0] minute, input logic [5:0] second);
    return {3'b000, day, 3'b000, hour, 2'b00, minute, 2'b00, second};
  endfunction

  function automatic logic [31:0] packTimeB(input logic [4:0] century, input logic [6:0] year,
                                            input logic [3:0] month);
    return {11'd0, century, 1'b0, year, 4'd0, month};
  endfunction

endpackage

// File: rtl/cal_rtc_monthlen.sv
module cal_rtc_monthlen (
  input  logic [3:0] month,
  input  logic [6:0] year,
  input  logic [4:0] century,
  output logic [4:0] days
);
  logic leapYear;

  // century*100 is a multiple of 4, so year%4 decides unless year is 0,
  // in which case the century's own divisibility by 4 decides.
  always_comb begin
    leapYear = (year[1:0] == 2'b00) && ((year != 7'd0) || (century[1:0] == 2'b00));
    unique case (month)
      4'd2:                      days = leapYear ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   days = 5'd30;
      default:                   days = 5'd31;
    endcase
  end
endmodule

// File: rtl/cal_rtc_ctrl.sv
module cal_rtc_ctrl
  import cal_rtc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [1:0]        ctrlWdata,
  input  logic [31:0]       liveA,
  input  logic [31:0]       liveB,
  input  logic [31:0]       holdA,
  input  logic [31:0]       holdB,
  output rtcStrobe_t        strobe,
  output logic [1:0]        ctrlQ,
  output logic [31:0]       busRdata
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             unusedAddrBits;
  logic             hitA, hitB, hitCtrl;

  assign idx            = busAddr[ADDR_W-1:2];
  assign unusedAddrBits = ^busAddr[1:0];
  assign hitA           = (idx == IDX_W'(IDX_TIME_A));
  assign hitB           = (idx == IDX_W'(IDX_TIME_B));
  assign hitCtrl        = (idx == IDX_W'(IDX_CTRL));

  always_ff @(posedge clk) begin
    if (!rstN)                 ctrlQ <= 2'b00;
    else if (busWr && hitCtrl) ctrlQ <= ctrlWdata;
  end

  always_comb begin
    strobe.load[0] = busWr && hitA && ctrlQ[CTL_UNLOCK];
    strobe.load[1] = busWr && hitB && ctrlQ[CTL_UNLOCK];
    strobe.snap[0] = busRd && hitA && ctrlQ[CTL_EN];
    strobe.snap[1] = busRd && hitB && ctrlQ[CTL_EN];
    strobe.advance = tick && ctrlQ[CTL_EN];
  end

  always_comb begin
    busRdata = 32'd0;
    if (busRd) begin
      if (hitA)         busRdata = ctrlQ[CTL_EN] ? liveA : holdA;
      else if (hitB)    busRdata = ctrlQ[CTL_EN] ? liveB : holdB;
      else if (hitCtrl) busRdata = {30'd0, ctrlQ};
      // alarm, alarm status and unmapped indices read zero
    end
  end
endmodule

// File: rtl/cal_rtc_time.sv
module cal_rtc_time
  import cal_rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  rtcStrobe_t  strobe,
  input  logic [31:0] wdata,
  output logic [31:0] liveA,
  output logic [31:0] liveB,
  output logic [31:0] holdA,
  output logic [31:0] holdB
);
  logic [5:0] secQ, minQ;
  logic [4:0] hourQ, dayQ, centQ;
  logic [3:0] monQ;
  logic [6:0] yearQ;
  logic [4:0] monthDays;
  logic       secWrap, minWrap, hourWrap, dayWrap, monWrap, yearWrap;

  cal_rtc_monthlen u_len (
    .month  (monQ),
    .year   (yearQ),
    .century(centQ),
    .days   (monthDays)
  );

  assign secWrap  = (secQ  >= 6'd59);
  assign minWrap  = (minQ  >= 6'd59);
  assign hourWrap = (hourQ >= 5'd23);
  assign dayWrap  = (dayQ  >= monthDays);
  assign monWrap  = (monQ  >= 4'd12);
  assign yearWrap = (yearQ >= 7'd99);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secQ <= '0; minQ <= '0; hourQ <= '0; dayQ <= '0;
      monQ <= '0; yearQ <= '0; centQ <= '0;
    end else if (|strobe.load) begin
      if (strobe.load[0]) begin
        dayQ  <= wdata[28:24];
        hourQ <= wdata[20:16];
        minQ  <= wdata[13:8];
        secQ  <= wdata[5:0];
      end
      if (strobe.load[1]) begin
        centQ <= wdata[20:16];
        yearQ <= wdata[14:8];
        monQ  <= wdata[3:0];
      end
    end else if (strobe.advance) begin
      secQ <= secWrap ? 6'd0 : secQ + 6'd1;
      if (secWrap) begin
        minQ <= minWrap ? 6'd0 : minQ + 6'd1;
        if (minWrap) begin
          hourQ <= hourWrap ? 5'd0 : hourQ + 5'd1;
          if (hourWrap) begin
            dayQ <= dayWrap ? 5'd1 : dayQ + 5'd1;
            if (dayWrap) begin
              monQ <= monWrap ? 4'd1 : monQ + 4'd1;
              if (monWrap) begin
                yearQ <= yearWrap ? 7'd0 : yearQ + 7'd1;
                if (yearWrap) centQ <= centQ + 5'd1;
              end
            end
          end
        end
      end
    end
  end

  assign liveA = packTimeA(dayQ, hourQ, minQ, secQ);
  assign liveB = packTimeB(centQ, yearQ, monQ);

  // holding registers, one per time word
  logic [31:0] liveW [2];
  logic [31:0] holdQ [2];
  assign liveW[0] = liveA;
  assign liveW[1] = liveB;

  for (genvar i = 0; i < 2; i++) begin : g_hold
    localparam logic [31:0] MASK = (i == 0) ? TIME_A_MASK : TIME_B_MASK;
    always_ff @(posedge clk) begin
      if (!rstN)               holdQ[i] <= '0;
      else if (strobe.load[i]) holdQ[i] <= wdata & MASK;
      else if (strobe.snap[i]) holdQ[i] <= liveW[i];
    end
  end

  assign holdA = holdQ[0];
  assign holdB = holdQ[1];
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import cal_rtc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata
);
  rtcStrobe_t  strobe;
  logic [1:0]  ctrlQ;
  logic [31:0] liveA, liveB, holdA, holdB;

  cal_rtc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busRd    (busRd),
    .ctrlWdata(busWdata[1:0]),
    .liveA    (liveA),
    .liveB    (liveB),
    .holdA    (holdA),
    .holdB    (holdB),
    .strobe   (strobe),
    .ctrlQ    (ctrlQ),
    .busRdata (busRdata)
  );

  cal_rtc_time u_time (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wdata (busWdata),
    .liveA (liveA),
    .liveB (liveB),
    .holdA (holdA),
    .holdB (holdB)
  );
endmodule

// File: rtl/cal_rtc_checker.sv
module cal_rtc_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic [1:0]        ctrlQ,
  input logic [31:0]       liveA,
  input logic [31:0]       liveB
);
  logic [ADDR_W-3:0] idx;
  logic timeIdx, quietIdx, timeLoad;
  assign idx      = busAddr[ADDR_W-1:2];
  assign timeIdx  = (idx == 0) || (idx == 1);
  assign quietIdx = !timeIdx && (idx != 4);
  assign timeLoad = busWr && timeIdx && ctrlQ[1];

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (liveA == 32'd0 && liveB == 32'd0 && ctrlQ == 2'b00));

  p_locked_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && timeIdx && !ctrlQ[1] && !(tick && ctrlQ[0])) |=> ($stable(liveA) && $stable(liveB)));

  p_ctrl_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && idx == 4) |=> (ctrlQ == $past(busWdata[1:0])));

  p_stopped_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ[0] && !timeLoad) |=> ($stable(liveA) && $stable(liveB)));

  p_second_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[0] && tick && !timeLoad && liveA[5:0] < 6'd59) |=> (liveA[5:0] == $past(liveA[5:0]) + 6'd1));

  p_quiet_read_r12: assert property (@(posedge clk) disable iff (!rstN)
    ((busRd && quietIdx) || !busRd) |-> (busRdata == 32'd0));
endmodule

bind cal_rtc cal_rtc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .tick    (tick),
  .busAddr (busAddr),
  .busWr   (busWr),
  .busRd   (busRd),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .ctrlQ   (ctrlQ),
  .liveA   (liveA),
  .liveB   (liveB)
);

// File: tb/cal_rtc_test.sv
module cal_rtc_test;
  localparam int ADDR_W = 8;
  localparam logic [7:0] A_TA = 8'h00, A_TB = 8'h04, A_AL = 8'h08, A_CT = 8'h10, A_AS = 8'h14;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tick = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWr = 1'b0;
  logic              busRd = 1'b0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;

  int vecs = 0;
  int fails = 0;

  cal_rtc #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata)
  );

  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [31:0] wordA(int d, int h, int m, int s);
    return 32'((d << 24) | (h << 16) | (m << 8) | s);
  endfunction

  function automatic logic [31:0] wordB(int c, int y, int mo);
    return 32'((c << 16) | (y << 8) | mo);
  endfunction

  function automatic int daysIn(int mo, int fullYear);
    if (mo == 2)
      return (((fullYear % 4 == 0) && (fullYear % 100 != 0)) || (fullYear % 400 == 0)) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 v = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic setTime(logic [31:0] a, logic [31:0] b);
    wr(A_CT, 32'h2);   // unlock, stopped
    wr(A_TA, a);
    wr(A_TB, b);
    wr(A_CT, 32'h1);   // run, locked
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic [31:0] snapA;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    rd(A_TA, v); check("R1 time A", v, 0);
    rd(A_TB, v); check("R1 time B", v, 0);
    rd(A_CT, v); check("R1 control", v, 0);
    ticks(4);
    rd(A_TA, v); check("R1 stopped after reset", v, 0);

    // R5: control read-back
    wr(A_CT, 32'hFFFF_FFFF); rd(A_CT, v); check("R5 control bits", v, 32'h3);
    wr(A_CT, 32'h0);         rd(A_CT, v); check("R5 control clear", v, 32'h0);

    // R4: locked write ignored; R2/R3 field positions via unlocked write
    wr(A_TA, 32'hFFFF_FFFF); rd(A_TA, v); check("R4 locked write A", v, 0);
    wr(A_CT, 32'h2);
    wr(A_TA, 32'hFFFF_FFFF); rd(A_TA, v); check("R2 word A mask", v, 32'h1F1F_3F3F);
    wr(A_TB, 32'hFFFF_FFFF); rd(A_TB, v); check("R3 word B mask", v, 32'h001F_7F0F);
    setTime(wordA(15, 10, 20, 30), wordB(20, 24, 3));
    rd(A_TA, v); check("R2 live word A", v, wordA(15, 10, 20, 30));
    rd(A_TB, v); check("R3 live word B", v, wordB(20, 24, 3));
    wr(A_TA, wordA(1, 1, 1, 1)); rd(A_TA, v); check("R4 locked while running", v, wordA(15, 10, 20, 30));
    wr(A_TB, wordB(1, 1, 1));    rd(A_TB, v); check("R4 locked B while running", v, wordB(20, 24, 3));

    // R12: alarm side and unmapped reads, writes ignored
    wr(A_AL, 32'hDEAD_BEEF); rd(A_AL, v); check("R12 alarm", v, 0);
    wr(A_AS, 32'hFFFF_FFFF); rd(A_AS, v); check("R12 alarm status", v, 0);
    rd(8'h0C, v); check("R12 gap index 3", v, 0);
    rd(8'h18, v); check("R12 index 6", v, 0);
    rd(8'hFC, v); check("R12 top index", v, 0);
    rd(8'h11, v); check("R2 low address bits ignored", v, 32'h1);
    rd(A_TA, v); check("R12 writes left time alone", v, wordA(15, 10, 20, 30));

    // R6/R7: near-exhaustive second/minute/hour stepping
    setTime(wordA(1, 0, 0, 0), wordB(20, 24, 1));
    for (int t = 1; t <= 130; t++) begin
      ticks(1);
      rd(A_TA, v);
      check("R6 per-tick step", v, wordA(1, t / 3600, (t / 60) % 60, t % 60));
    end
    ticks(3725 - 130);
    rd(A_TA, v); check("R7 hour carry", v, wordA(1, 1, 2, 5));
    setTime(wordA(4, 23, 59, 58), wordB(20, 24, 1));
    ticks(3);
    rd(A_TA, v); check("R7 day carry", v, wordA(5, 0, 0, 1));

    // R6: tick ignored while stopped
    wr(A_CT, 32'h0); ticks(10); wr(A_CT, 32'h1);
    rd(A_TA, v); check("R6 no advance when stopped", v, wordA(5, 0, 0, 1));

    // R11: holding register while stopped
    rd(A_TA, snapA);
    ticks(5);
    wr(A_CT, 32'h0);
    rd(A_TA, v); check("R11 stopped read holds snapshot", v, snapA);
    wr(A_CT, 32'h1);
    rd(A_TA, v); check("R11 running read is live", v, wordA(5, 0, 0, 6));
    wr(A_CT, 32'h2); wr(A_TB, wordB(7, 8, 9)); wr(A_CT, 32'h0);
    rd(A_TB, v); check("R11 stopped read after write", v, wordB(7, 8, 9));

    // R8/R9/R10: month ends over years covering each leap branch
    begin
      int cs[6] = '{19, 20, 20, 20, 21, 24};
      int ys[6] = '{0, 0, 23, 24, 0, 0};
      for (int k = 0; k < 6; k++) begin
        for (int mo = 1; mo <= 12; mo++) begin
          int len, ny, nc, nmo;
          len = daysIn(mo, cs[k] * 100 + ys[k]);
          setTime(wordA(len - 1, 23, 59, 59), wordB(cs[k], ys[k], mo));
          ticks(1);
          rd(A_TA, v);
          check(mo == 2 ? "R9 february last day" : "R8 month last day", v, wordA(len, 0, 0, 0));
          setTime(wordA(len, 23, 59, 59), wordB(cs[k], ys[k], mo));
          ticks(1);
          rd(A_TA, v);
          check(mo == 2 ? "R9 february wrap" : "R8 day wrap", v, wordA(1, 0, 0, 0));
          nmo = (mo == 12) ? 1 : mo + 1;
          ny  = (mo == 12) ? ys[k] + 1 : ys[k];
          nc  = cs[k];
          if (ny == 100) begin ny = 0; nc++; end
          rd(A_TB, v);
          check(mo == 12 ? "R10 year step" : "R8 month step", v, wordB(nc, ny, nmo));
        end
      end
    end

    // R10: century rollover
    setTime(wordA(31, 23, 59, 59), wordB(20, 99, 12));
    ticks(1);
    rd(A_TA, v); check("R10 century word A", v, wordA(1, 0, 0, 0));
    rd(A_TB, v); check("R10 century word B", v, wordB(21, 0, 1));

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule